// File: doc/BRIEF.md
# Word-Interleaved Block Fill Memory

This block answers cache-block read requests from four memory banks that are interleaved by word: word address `a` lives in bank `a mod 4`, at row `a / 4`. A requester presents a word address and a one-cycle request strobe. Every bank receives the row in the same cycle and performs its fixed-latency access alongside the others. The four words are then returned over a single one-word return path, one per cycle, in bank order. A fill therefore takes 1 address cycle, 6 access cycles and 4 transfer cycles, or 11 cycles in total.

A parameter selects a serial comparison mode. In that mode each word still comes from its own bank, but the next bank access starts only after the previous word has left the return path. Each word then costs 1 + 6 + 1 cycles, and a block costs 32. Each bank owns a small synchronous array, and a separate load port preloads it. Only one fill is in flight at any time. The block reports this through a busy output, and it ignores any strobe that arrives while busy is high.

Top module: `ilv_fill_mem`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `rd_valid` and `done` are all 0.
- R2: When `ld_en` is high, a clock edge writes `ld_data` into bank `ld_addr[1:0]` at row `ld_addr[7:2]`. Loading never changes `busy`, `rd_valid` or `done`.
- R3: A `req` seen high at a clock edge while `busy` is low is accepted. Counting the request cycle as cycle 1, `busy` is high from cycle 2 up to and including the cycle in which `done` is high, and it is low in the cycle after that.
- R4: In interleaved mode (`INTERLEAVE=1`), word k (k = 0..3) is on `rd_data` with `rd_valid` high in cycle 8+k, counting the request cycle as cycle 1. The last word therefore arrives in cycle 11.
- R5: Word k of a fill is the word stored at address `{req_addr[7:2], k}`, so the words come out in bank order 0, 1, 2, 3.
- R6: The two low bits of `req_addr` have no effect on which words are returned or when they are returned.
- R7: A `req` that arrives while `busy` is high, including in the cycle where `done` is high, is ignored. The fill in progress is unchanged, and no further fill follows.
- R8: In serial mode (`INTERLEAVE=0`), word k is valid in cycle 8+8k, so the last word arrives in cycle 32. `rd_valid` is low in every cycle between two words.
- R9: Each fill raises `rd_valid` in exactly four cycles. `done` is high only together with the fourth word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Preload write enable |
| ld_addr | input | 8 | Preload word address |
| ld_data | input | 32 | Preload word |
| req | input | 1 | Block read request strobe |
| req_addr | input | 8 | Word address of the block; bits [1:0] are ignored |
| busy | output | 1 | A fill is in progress; new requests are ignored |
| rd_valid | output | 1 | `rd_data` holds a returned word |
| rd_data | output | 32 | Returned word |
| done | output | 1 | The last word of the fill is on `rd_data` |

## Verification
The bench fills every block of the address space in interleaved mode. Each request uses different low address bits, so a fault in bank selection or in row extraction shows up as a wrong word at a known position. A second instance runs in serial mode over a subset of blocks, which separates the overlapped timing from the sequential timing cycle by cycle. Some fills have extra strobes injected mid-fill and on the done cycle, which separates a controller that properly holds off requests from one that restarts or chains a fill.

// File: rtl/ilv_pkg.sv
// Package ilv_pkg: shared types for the interleaved fill memory.
// Assumes nothing beyond being compiled before the modules that import it.
package ilv_pkg;
    // Controller phases of one fill.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ADDR   = 2'd1,
        ST_ACCESS = 2'd2,
        ST_XFER   = 2'd3
    } fill_st_t;
endpackage

// File: rtl/ilv_bank.sv
// Module ilv_bank: one memory bank with a synchronous write port and a
// registered read port. The read result appears the cycle after rd_en.
// Assumes writes and reads to the same row are never issued in one cycle.
module ilv_bank #(
    parameter int DATA_W = 32,
    parameter int ROW_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [DATA_W-1:0] rd_q
);
    localparam int ROWS = 1 << ROW_W;

    logic [DATA_W-1:0] mem [ROWS];

    // Store a preloaded word.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_row] <= wr_data;
    end

    // Capture the accessed word at the end of the access window.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= mem[rd_row];
    end
endmodule

// File: rtl/ilv_ctrl.sv
// Module ilv_ctrl: sequences one block fill. The request cycle doubles as
// the address cycle. ACC_CYC access cycles follow, and then BANKS transfer
// cycles (interleaved) or BANKS rounds of address/access/transfer (serial).
// Assumes BANKS is a power of two >= 2 and ACC_CYC >= 1.
module ilv_ctrl
    import ilv_pkg::*;
#(
    parameter int BANKS      = 4,
    parameter int ROW_W      = 6,
    parameter int ACC_CYC    = 6,
    parameter bit INTERLEAVE = 1'b1,
    localparam int IDX_W     = $clog2(BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [ROW_W-1:0] req_row,
    output logic             busy,
    output logic [BANKS-1:0] rd_en,
    output logic [ROW_W-1:0] rd_row,
    output logic [IDX_W-1:0] word_idx,
    output logic             rd_valid,
    output logic             done
);
    localparam int CNT_W = $clog2(ACC_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACC_CYC - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BANKS - 1);

    fill_st_t         st;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] widx;
    logic [ROW_W-1:0] row_q;

    // Phase sequencing, access countdown and word index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            widx  <= '0;
            row_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req) begin
                    row_q <= req_row;
                    cnt   <= '0;
                    widx  <= '0;
                    st    <= ST_ACCESS;
                end
                ST_ADDR: begin
                    cnt <= '0;
                    st  <= ST_ACCESS;
                end
                ST_ACCESS: begin
                    if (cnt == CNT_LAST) st  <= ST_XFER;
                    else                 cnt <= cnt + 1'b1;
                end
                default: begin
                    if (widx == IDX_LAST) begin
                        st <= ST_IDLE;
                    end else begin
                        widx <= widx + 1'b1;
                        st   <= INTERLEAVE ? ST_XFER : ST_ADDR;
                    end
                end
            endcase
        end
    end

    // Status outputs derived from the phase.
    always_comb begin
        busy     = (st != ST_IDLE);
        rd_valid = (st == ST_XFER);
        done     = (st == ST_XFER) && (widx == IDX_LAST);
        rd_row   = row_q;
        word_idx = widx;
    end

    // Bank read strobes: all banks at once, or only the current one.
    for (genvar b = 0; b < BANKS; b++) begin : g_rden
        if (INTERLEAVE) begin : g_par
            assign rd_en[b] = (st == ST_ACCESS) && (cnt == CNT_LAST);
        end else begin : g_ser
            assign rd_en[b] = (st == ST_ACCESS) && (cnt == CNT_LAST) &&
                              (widx == IDX_W'(b));
        end
    end

    // Checker-only count of words returned in the current fill.
    logic [IDX_W:0] vcnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                vcnt <= '0;
        else if (req && !busy)     vcnt <= '0;
        else if (rd_valid)         vcnt <= vcnt + 1'b1;
    end

    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> (busy && !rd_valid)); // R3
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R3
    AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rd_row)); // R7
    AST_FOUR_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vcnt == (IDX_W+1)'(BANKS - 1))); // R9
    AST_ONE_READ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_en) |=> rd_valid); // R4

    if (INTERLEAVE) begin : g_chk_par
        AST_BURST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_valid && !done) |=> rd_valid); // R4
    end else begin : g_chk_ser
        AST_SERIAL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_valid && !done) |=> !rd_valid); // R8
    end
endmodule

// File: rtl/ilv_fill_mem.sv
// Module ilv_fill_mem: top of the word-interleaved block fill memory.
// The low IDX_W address bits select the bank and the rest select the row.
// A fill returns BANKS words in bank order through a one-word output.
// Assumes ADDR_W > log2(BANKS) and a single requester.
module ilv_fill_mem
    import ilv_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int BANKS      = 4,
    parameter int ACC_CYC    = 6,
    parameter bit INTERLEAVE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    localparam int IDX_W = $clog2(BANKS);
    localparam int ROW_W = ADDR_W - IDX_W;

    logic [BANKS-1:0]  rd_en;
    logic [ROW_W-1:0]  rd_row;
    logic [IDX_W-1:0]  word_idx;
    logic [DATA_W-1:0] bank_q [BANKS];
    logic              req_lo_unused;

    assign req_lo_unused = ^req_addr[IDX_W-1:0];

    ilv_ctrl #(
        .BANKS      (BANKS),
        .ROW_W      (ROW_W),
        .ACC_CYC    (ACC_CYC),
        .INTERLEAVE (INTERLEAVE)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_row  (req_addr[ADDR_W-1:IDX_W]),
        .busy     (busy),
        .rd_en    (rd_en),
        .rd_row   (rd_row),
        .word_idx (word_idx),
        .rd_valid (rd_valid),
        .done     (done)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        ilv_bank #(
            .DATA_W (DATA_W),
            .ROW_W  (ROW_W)
        ) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (ld_en && (ld_addr[IDX_W-1:0] == IDX_W'(b))),
            .wr_row  (ld_addr[ADDR_W-1:IDX_W]),
            .wr_data (ld_data),
            .rd_en   (rd_en[b]),
            .rd_row  (rd_row),
            .rd_q    (bank_q[b])
        );
    end

    // Put the current bank's word onto the one-word return path.
    always_comb begin
        rd_data = bank_q[word_idx];
    end

    AST_DATA_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy); // R9
    AST_LOAD_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !busy && !req) |=> !busy); // R2
endmodule

// File: tb/ilv_fill_mem_tb.sv
// Bench for ilv_fill_mem: one interleaved and one serial instance share a
// preload, then blocks are filled and every cycle of each fill is checked.
module ilv_fill_mem_tb_top;
    localparam int DW = 32;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic          req_p = 1'b0, req_s = 1'b0;
    logic [AW-1:0] addr_p = '0, addr_s = '0;
    logic          busy_p, valid_p, done_p, busy_s, valid_s, done_s;
    logic [DW-1:0] data_p, data_s;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ilv_fill_mem #(.INTERLEAVE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .req(req_p), .req_addr(addr_p), .busy(busy_p),
        .rd_valid(valid_p), .rd_data(data_p), .done(done_p));

    ilv_fill_mem #(.INTERLEAVE(1'b0)) dut_serial_i (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .req(req_s), .req_addr(addr_s), .busy(busy_s),
        .rd_valid(valid_s), .rd_data(data_s), .done(done_s));

    function automatic logic [DW-1:0] pat(int a);
        return (DW'(a) * 32'h9E3779B1) ^ 32'h5A5A0000 ^ DW'(a);
    endfunction

    task automatic chk(bit ok, string rq, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    // One fill on the chosen instance. Cycle numbers count the request cycle as 1.
    task automatic run_fill(bit serial, int blk, logic [1:0] lo, bit poke);
        int stride = serial ? 8 : 1;
        int last   = 8 + 3 * stride;
        @(negedge clk);
        if (serial) begin req_s = 1'b1; addr_s = {blk[5:0], lo}; end
        else        begin req_p = 1'b1; addr_p = {blk[5:0], lo}; end
        for (int c = 2; c <= last + 1; c++) begin
            bit ev, ed, eb, pk;
            int k;
            logic v, d, b;
            logic [DW-1:0] q;
            @(negedge clk);
            pk = poke && (c == 4 || c == last);
            if (serial) begin req_s = pk; addr_s = {~blk[5:0], ~lo}; end
            else        begin req_p = pk; addr_p = {~blk[5:0], ~lo}; end
            v = serial ? valid_s : valid_p;
            d = serial ? done_s  : done_p;
            b = serial ? busy_s  : busy_p;
            q = serial ? data_s  : data_p;
            k  = (c - 8) / stride;
            ev = (c >= 8) && ((c - 8) % stride == 0) && (k < 4);
            ed = ev && (k == 3);
            eb = (c <= last);
            chk(v == ev, serial ? "R8 valid timing" : "R4 valid timing", DW'(v), DW'(ev));
            chk(d == ed, "R9 done with last word", DW'(d), DW'(ed));
            chk(b == eb, poke ? "R7 busy under extra request" : "R3 busy window", DW'(b), DW'(eb));
            if (ev) chk(q == pat(blk * 4 + k), "R5 R6 word order and data", q, pat(blk * 4 + k));
        end
        // After the fill, an ignored strobe must not start another one.
        @(negedge clk);
        chk((serial ? busy_s : busy_p) == 1'b0, "R7 no chained fill",
            DW'(serial ? busy_s : busy_p), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_p == 0 && valid_p == 0 && done_p == 0, "R1 reset state", DW'({busy_p, valid_p, done_p}), '0);
        chk(busy_s == 0 && valid_s == 0 && done_s == 0, "R1 reset state serial", DW'({busy_s, valid_s, done_s}), '0);
        rst_n = 1'b1;
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = AW'(a); ld_data = pat(a);
            if (a > 0) chk(busy_p == 0 && valid_p == 0 && done_p == 0, "R2 load leaves status idle",
                           DW'({busy_p, valid_p, done_p}), '0);
        end
        @(negedge clk);
        ld_en = 1'b0;
        for (int blk = 0; blk < 64; blk++)
            run_fill(1'b0, blk, 2'(blk), (blk % 5) == 2);
        for (int blk = 0; blk < 64; blk += 5)
            run_fill(1'b1, blk, 2'(blk + 1), (blk % 2) == 1);
        chk(busy_p == 0 && busy_s == 0, "R3 both idle at end", DW'({busy_p, busy_s}), '0);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule